// File: doc/BRIEF.md
# Dual-Width Memory Bus Adapter

This block sits between a host-side memory bus and a 16-bit memory array. It turns the host's chip-enable, output-enable and write-enable strobes into array reads and array write beats. A width input picks either a full 16-bit data path or an 8-bit one. In 8-bit mode the top data pin is no longer data. It becomes the least significant address bit and chooses which half of the array word is seen on, or written from, the low eight pins. Per-pin output enables tell the pad ring which data pins to drive. Every pin left undriven floats.

An identifier mode replaces array data with one of two fixed 16-bit codes, a manufacturer code and a device code. Address bit 0 chooses between them. The single-bit `id_mode` input stands for the high-voltage detect that would enable this mode. All pin inputs are sampled on `clk`. Read data, output enables and write beats are registered, so each appears one cycle after the sample that caused it. The array side accepts a read address and a write beat in every cycle. It can apply no back-pressure, so there is no ready signal and a write beat is never held or repeated.

Top module: `bwa_bus_adapter`

## Requirements
- R1: While `rst_n` is low, all `dq_oe` bits are 0 and `arr_wr` is 0.
- R2: When `ce_n` or `oe_n` was sampled high, every bit of `dq_oe` is 0 in the following cycle.
- R3: A read sampled with `ce_n`=0, `oe_n`=0, `wide_i`=1 and `id_mode`=0 sets all 16 `dq_oe` bits in the next cycle. In that cycle `dq_out` equals the array word at `addr_i`.
- R4: When `wide_i`=0 (8-bit mode), `dq_oe[15:8]` is 0 in the next cycle. A qualified read drives exactly `dq_oe[7:0]`.
- R5: In an 8-bit read outside identifier mode, `dq_in[15]`=1 puts array bits 15:8 on `dq_out[7:0]`, and `dq_in[15]`=0 puts bits 7:0 there. `dq_out[15:8]` reads 0.
- R6: In identifier mode with `wide_i`=1, a qualified read returns `MFR_CODE` when `addr_i[0]`=0 and `DEV_CODE` when `addr_i[0]`=1, whatever the array holds.
- R7: In identifier mode with `wide_i`=0, a qualified read returns the low byte of the selected code on `dq_out[7:0]`. `dq_in[15]` has no effect on the result.
- R8: A write beat (`arr_wr`=1 for exactly one cycle) follows the first sample of `we_n`=1 after a sample of `we_n`=0. It appears one cycle after that sample. The beat is issued only if `ce_n` was 0 in the last low sample of `we_n`. It carries the address and data sampled in that last low sample.
- R9: A 16-bit write sets `arr_wstrb`=2'b11 and carries the full data word. An 8-bit write copies `dq_in[7:0]` into both halves of `arr_wdata`. It sets `arr_wstrb`=2'b10 when `dq_in[15]` was 1 and 2'b01 when it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 selects 16-bit data path, 0 selects 8-bit |
| id_mode | input | 1 | Identifier read mode |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | 17 | Host word address |
| dq_in | input | 16 | Data pins as seen from the pad inputs |
| dq_out | output | 16 | Data to the pad outputs |
| dq_oe | output | 16 | Per-pin output enable |
| arr_addr | output | 17 | Array read address |
| arr_rdata | input | 16 | Array read word for `arr_addr`, same cycle |
| arr_wr | output | 1 | Write beat strobe |
| arr_waddr | output | 17 | Write beat address |
| arr_wdata | output | 16 | Write beat data |
| arr_wstrb | output | 2 | Write beat byte-lane strobes |

## Verification
The properties assume that every host strobe is already synchronous to `clk` and is sampled only at rising edges. They also assume that the host never asserts `oe_n` and `we_n` together. The bench drives every input on the falling edge and keeps `oe_n` high throughout each write. The identifier checks rely on the array answering `arr_addr` in the same cycle. The array model in the bench is a pure function of the address, so a wrong identifier multiplex shows up as an array-derived value.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} bus_mode_e;
  localparam int unsigned LANES = 2;

  function automatic logic [LANES-1:0] lane_strobe(input bus_mode_e mode, input logic hi_lane);
    if (mode == MODE_WIDE) return '1;
    return hi_lane ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/bwa_read_steer.sv
module bwa_read_steer #(
  parameter int unsigned LANE_W = 8,
  parameter logic [2*LANE_W-1:0] MFR_CODE = 16'h0089,
  parameter logic [2*LANE_W-1:0] DEV_CODE = 16'h2274,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              wide,
  input  logic              id_sel,
  input  logic              code_pick,
  input  logic              top_pin,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] steered
);
  logic [DATA_W-1:0] code, src;

  always_comb begin
    code = code_pick ? DEV_CODE : MFR_CODE;
    src  = id_sel ? code : rdata;
    if (wide) begin
      steered = src;
    end else begin
      steered = '0;
      // byte address on the top pin is ignored for identifier reads
      steered[LANE_W-1:0] = (!id_sel && top_pin) ? src[DATA_W-1:LANE_W] : src[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/bwa_oe_gen.sv
module bwa_oe_gen #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              wide,
  output logic [DATA_W-1:0] oe
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    logic en;
    if (i < LANE_W) begin : g_low
      assign en = drive;
    end else begin : g_upper
      // upper pins float in narrow mode; the top one becomes an address input
      assign en = drive & wide;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe[i] <= 1'b0;
      else        oe[i] <= en;
    end
  end
endmodule

// File: rtl/bwa_write_cap.sv
module bwa_write_cap
  import bwa_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 17,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              wr,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wstrb
);
  logic              we_q, armed, lat_wide;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_dq;
  logic              rise;

  assign rise = we_n && !we_q && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      armed    <= 1'b0;
      lat_wide <= 1'b0;
      lat_addr <= '0;
      lat_dq   <= '0;
      wr       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
      wstrb    <= '0;
    end else begin
      we_q <= we_n;
      wr   <= 1'b0;
      if (!we_n) begin
        armed    <= !ce_n;
        lat_wide <= wide;
        lat_addr <= addr;
        lat_dq   <= dq;
      end
      if (rise) begin
        wr    <= 1'b1;
        waddr <= lat_addr;
        wdata <= lat_wide ? lat_dq : {LANES{lat_dq[LANE_W-1:0]}};
        wstrb <= lane_strobe(bus_mode_e'(lat_wide), lat_dq[DATA_W-1]);
      end
    end
  end
endmodule

// File: rtl/bwa_bus_adapter.sv
module bwa_bus_adapter
  import bwa_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 17,
  parameter logic [2*LANE_W-1:0] MFR_CODE = 16'h0089,
  parameter logic [2*LANE_W-1:0] DEV_CODE = 16'h2274,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              id_mode,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [LANES-1:0]  arr_wstrb
);
  logic              drive;
  logic [DATA_W-1:0] steered;

  assign drive    = !ce_n && !oe_n;
  assign arr_addr = addr_i;

  bwa_read_steer #(.LANE_W(LANE_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_steer (
    .wide(wide_i), .id_sel(id_mode), .code_pick(addr_i[0]),
    .top_pin(dq_in[DATA_W-1]), .rdata(arr_rdata), .steered(steered)
  );

  bwa_oe_gen #(.LANE_W(LANE_W)) u_oe (
    .clk(clk), .rst_n(rst_n), .drive(drive), .wide(wide_i), .oe(dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dq_out <= '0;
    else if (drive) dq_out <= steered;
    else            dq_out <= '0;
  end

  bwa_write_cap #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .wide(wide_i),
    .addr(addr_i), .dq(dq_in), .wr(arr_wr), .waddr(arr_waddr),
    .wdata(arr_wdata), .wstrb(arr_wstrb)
  );
endmodule

// File: rtl/bwa_bus_adapter_sva.sv
module bwa_bus_adapter_sva #(
  parameter int unsigned LANE_W = 8,
  parameter logic [2*LANE_W-1:0] MFR_CODE = 16'h0089,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wide_i,
  input logic              id_mode,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              addr0,
  input logic [DATA_W-1:0] dq_out,
  input logic [DATA_W-1:0] dq_oe,
  input logic              arr_wr,
  input logic [1:0]        arr_wstrb
);
  a_r2_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> (dq_oe == '0));

  a_r3_wide_all_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && wide_i) |=> (&dq_oe));

  a_r4_narrow_upper_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i) |=> (dq_oe[DATA_W-1:LANE_W] == '0));

  a_r6_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && wide_i && id_mode && !addr0) |=> (dq_out == MFR_CODE));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |=> !arr_wr);

  a_r8_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> ($past(we_n) && !$past(we_n, 2)));

  a_r9_strobe_set: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> (arr_wstrb != 2'b00));
endmodule

bind bwa_bus_adapter bwa_bus_adapter_sva #(.LANE_W(LANE_W), .MFR_CODE(MFR_CODE)) u_sva (
  .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .id_mode(id_mode), .ce_n(ce_n),
  .oe_n(oe_n), .we_n(we_n), .addr0(addr_i[0]), .dq_out(dq_out), .dq_oe(dq_oe),
  .arr_wr(arr_wr), .arr_wstrb(arr_wstrb)
);

// File: tb/bwa_bus_adapter_tb.sv
module bwa_bus_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MFR = 16'h0089;
  localparam logic [15:0] DEV = 16'h2274;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_i = 1'b1, id_mode = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr_i = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, arr_rdata, arr_wdata;
  logic [16:0] arr_addr, arr_waddr;
  logic arr_wr;
  logic [1:0] arr_wstrb;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] word_of(input logic [16:0] a);
    int unsigned v;
    v = {15'd0, a} * 40503 + 32'h1D2B;
    return v[15:0] ^ {a[7:0], a[16:9]};
  endfunction

  assign arr_rdata = word_of(arr_addr);

  bwa_bus_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .id_mode(id_mode), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr_i(addr_i), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_wr(arr_wr),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_wstrb(arr_wstrb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input bit w, input bit id, input bit c, input bit o,
                         input bit top, input logic [16:0] a);
    logic [15:0] code, src, exp_d, exp_oe;
    bit drv;
    @(negedge clk);
    wide_i = w; id_mode = id; ce_n = c; oe_n = o; we_n = 1'b1;
    addr_i = a; dq_in = {top, 15'h5A5A};
    drv = !c && !o;
    code = a[0] ? DEV : MFR;
    src = id ? code : word_of(a);
    if (w) exp_d = src;
    else if (id) exp_d = {8'h00, code[7:0]};
    else exp_d = {8'h00, top ? src[15:8] : src[7:0]};
    exp_oe = !drv ? 16'h0000 : (w ? 16'hFFFF : 16'h00FF);
    @(negedge clk);
    if (!drv) chk("R2 float", dq_oe, exp_oe);
    else if (w) chk("R3 wide enables", dq_oe, exp_oe);
    else chk("R4 narrow enables", dq_oe, exp_oe);
    if (drv) begin
      if (id && w) chk("R6 id wide data", dq_out, exp_d);
      else if (id) chk("R7 id narrow data", dq_out, exp_d);
      else if (w) chk("R3 wide data", dq_out, exp_d);
      else chk("R5 byte steer data", dq_out, exp_d);
    end
  endtask

  task automatic do_write(input bit w, input bit c, input bit top,
                          input logic [16:0] a, input logic [15:0] d);
    logic [15:0] pin, exp_d;
    logic [1:0] exp_s;
    @(negedge clk);
    pin = {top, d[14:0]};
    wide_i = w; id_mode = 1'b0; ce_n = c; oe_n = 1'b1; we_n = 1'b0;
    addr_i = a; dq_in = pin;
    @(negedge clk);
    chk("R8 no beat while low", arr_wr, 0);
    we_n = 1'b1; ce_n = 1'b1; addr_i = ~a; dq_in = ~pin;
    @(negedge clk);
    chk("R8 beat issued", arr_wr, !c);
    if (!c) begin
      exp_d = w ? pin : {pin[7:0], pin[7:0]};
      exp_s = w ? 2'b11 : (top ? 2'b10 : 2'b01);
      chk("R8 beat addr", arr_waddr, a);
      chk("R9 beat data", arr_wdata, exp_d);
      chk("R9 beat strobe", arr_wstrb, exp_s);
    end
    @(negedge clk);
    chk("R8 single cycle", arr_wr, 0);
  endtask

  initial begin
    logic [16:0] addrs [5];
    addrs[0] = 17'h00000; addrs[1] = 17'h00001; addrs[2] = 17'h1234A;
    addrs[3] = 17'h1FFFF; addrs[4] = 17'h0ABCD;
    repeat (3) @(negedge clk);
    chk("R1 reset enables", dq_oe, 0);
    chk("R1 reset beat", arr_wr, 0);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int id = 0; id < 2; id++)
        for (int c = 0; c < 2; c++)
          for (int o = 0; o < 2; o++)
            for (int t = 0; t < 2; t++)
              for (int k = 0; k < 5; k++)
                do_read(w[0], id[0], c[0], o[0], t[0], addrs[k]);
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 2; c++)
        for (int t = 0; t < 2; t++)
          for (int k = 0; k < 5; k++)
            do_write(w[0], c[0], t[0], addrs[k], 16'h3C5A ^ {addrs[k][15:0]});
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule